// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This clocked controller turns a three-level switching command into two gate enables for one synchronous buck phase: a high-side enable and a low-side enable. The command reaches the block as two digitised comparator flags. One flag marks the upper level and the other marks the lower level. When neither flag is set, or both are, the command is at midlevel. The block also takes a supply-good flag, a mode select, a zero-crossing flag, an over-temperature flag, and two gate-off sense flags that report whether each driven gate has actually discharged. Every one of these inputs passes through a two-flop synchroniser before the state machine uses it.

Before either gate turns on, the opposite gate must be reported off by its sense flag, and both gates must have been off for at least a set number of cycles. A midlevel command that lasts long enough parks the block in a low-power sleep state. Any firm command leaves sleep at once. In pulse-skipping mode, a zero crossing cuts the low-side on-time short. A gate sense that never confirms within a timeout latches a fault, and the fault disables both gates until reset.

Top module: `gdrv_sequencer`

## Requirements
- R1: A high command (upper flag 1, lower flag 0) held steady leads to high-side enable 1 and low-side enable 0.
- R2: A low command (lower flag 1, upper flag 0) held steady leads to low-side enable 1 and high-side enable 0, in either mode, unless a truncation lock is active (R10).
- R3: A midlevel command (both flags 0, or both flags 1) drops both enables on the (MID_HOLD_CYC+2)-th rising edge after the flags change. A midlevel that ends sooner leaves the enables as they were.
- R4: From sleep, a high or low command turns its gate on at the (DEAD_MIN_CYC+3)-th rising edge after the flags change, with no midlevel hold applied.
- R5: The high-side and low-side enables are never 1 in the same cycle.
- R6: A gate turns on only when the synchronised off-sense of the opposite gate reads 1. While the low-side sense stays 0, the high side never turns on.
- R7: Between one gate turning off and the other turning on, both enables stay 0 for at least DEAD_MIN_CYC cycles.
- R8: While supply-good is 0, both enables are 0. Once supply-good is 1 and the command is low, the low side turns on at the (DEAD_MIN_CYC+3)-th edge.
- R9: Mode select 1 means forced-continuous mode, in which the zero-crossing flag has no effect on the low side. Mode select 0 means pulse-skipping mode.
- R10: In pulse-skipping mode, a zero-crossing flag of 1 turns the low side off on the 3rd rising edge. The low side then stays off under a low command until a high-side pulse has completed.
- R11: An over-temperature flag of 1 turns both enables off on the 3rd rising edge. Normal switching resumes after the flag clears.
- R12: If the off-sense a wait state needs has not read 1 within SENSE_TMO_CYC cycles, both enables go to 0 and the fault output goes to 1. The fault output and the disabled state hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hi_flag | input | 1 | Command above upper threshold (asynchronous) |
| cmd_lo_flag | input | 1 | Command below lower threshold (asynchronous) |
| supply_ok | input | 1 | Gate supply above lockout level (asynchronous) |
| cont_mode | input | 1 | 1 = forced-continuous, 0 = pulse-skipping (asynchronous) |
| zero_cross | input | 1 | Inductor current reached zero (asynchronous) |
| hs_off_sense | input | 1 | High-side gate sensed discharged (asynchronous) |
| ls_off_sense | input | 1 | Low-side gate sensed discharged (asynchronous) |
| over_temp | input | 1 | Over-temperature flag (asynchronous) |
| hs_gate_en | output | 1 | High-side gate enable |
| ls_gate_en | output | 1 | Low-side gate enable |
| sense_fault | output | 1 | Sticky gate-sense timeout fault |

## Verification
Each state drives the two enables directly, so a wrong state shows at the ports on the same edge it is entered. It appears either as a gate that turns on too early or as a missing enable. A dead-time counter that restarts at the wrong time shortens the both-off gap, and the bench measures that gap on every handover. A midlevel timer or synchroniser that is off by one moves the drop or start edge away from the exact edge that R3, R4, R10 and R11 name. A lock or fault flag that fails to hold shows up as a low side that turns back on, or a gate that recovers, within a few cycles of the stimulus being released.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

  typedef enum logic [2:0] {
    ST_OFF         = 3'd0,
    ST_LS_ON       = 3'd1,
    ST_WAIT_LS_OFF = 3'd2,
    ST_HS_ON       = 3'd3,
    ST_WAIT_HS_OFF = 3'd4,
    ST_SLEEP       = 3'd5
  } gdrv_state_e;

  typedef enum logic [1:0] {
    CMD_MID  = 2'd0,
    CMD_HIGH = 2'd1,
    CMD_LOW  = 2'd2
  } gdrv_cmd_e;

  // Two threshold flags: exactly one set is a firm level, otherwise midlevel.
  function automatic gdrv_cmd_e decode_cmd(input logic above, input logic below);
    if (above && !below) return CMD_HIGH;
    if (below && !above) return CMD_LOW;
    return CMD_MID;
  endfunction

  // True when the cycle being counted now is the lim-th one.
  function automatic logic count_reached(input int cnt, input int lim);
    return (cnt + 1) >= lim;
  endfunction

endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/gdrv_mid_timer.sv
module gdrv_mid_timer
  import gdrv_pkg::*;
#(
  parameter int HOLD_CYC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mid_now,
  output logic expired
);

  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!mid_now)     cnt_q <= '0;
    else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + CW'(1);
  end

  assign expired = mid_now && count_reached(int'(cnt_q), HOLD_CYC);

  if (HOLD_CYC > 1) begin : g_chk
    // A freshly started midlevel must not expire on its first cycle (R3).
    assert_no_early_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_now && !$past(mid_now)) |-> !expired);
  end

endmodule

// File: rtl/gdrv_gap_timer.sv
module gdrv_gap_timer
  import gdrv_pkg::*;
#(
  parameter int DEAD_CYC = 2,
  parameter int TMO_CYC  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  input  logic restart,
  output logic dead_ok,
  output logic timed_out,
  output logic [$clog2(TMO_CYC+1)-1:0] gap_cnt
);

  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(TMO_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || !waiting) cnt_q <= '0;
    else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + CW'(1);
  end

  assign dead_ok   = waiting && count_reached(int'(cnt_q), DEAD_CYC);
  assign timed_out = waiting && count_reached(int'(cnt_q), TMO_CYC);
  assign gap_cnt   = cnt_q;

  // Timeout can only be reported once the dead-time window has passed (R12).
  assert_tmo_after_dead_R12: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> dead_ok);

endmodule

// File: rtl/gdrv_sequencer.sv
module gdrv_sequencer
  import gdrv_pkg::*;
#(
  parameter int MID_HOLD_CYC  = 15,
  parameter int DEAD_MIN_CYC  = 2,
  parameter int SENSE_TMO_CYC = 32,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_hi_flag,
  input  logic cmd_lo_flag,
  input  logic supply_ok,
  input  logic cont_mode,
  input  logic zero_cross,
  input  logic hs_off_sense,
  input  logic ls_off_sense,
  input  logic over_temp,
  output logic hs_gate_en,
  output logic ls_gate_en,
  output logic sense_fault
);

  localparam int NUM_IN = 8;
  localparam int GW = $clog2(SENSE_TMO_CYC + 1);

  // ---- synchronised inputs ----
  logic [NUM_IN-1:0] raw_vec, syn_vec;
  assign raw_vec = {over_temp, zero_cross, cont_mode, supply_ok,
                    ls_off_sense, hs_off_sense, cmd_lo_flag, cmd_hi_flag};

  gdrv_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_vec), .q(syn_vec));

  logic hi_s, lo_s, hs_off_s, ls_off_s, supply_s, cont_s, zc_s, ot_s;
  assign {ot_s, zc_s, cont_s, supply_s, ls_off_s, hs_off_s, lo_s, hi_s} = syn_vec;

  gdrv_cmd_e cmd;
  logic cmd_high, cmd_low, cmd_mid;
  assign cmd      = decode_cmd(hi_s, lo_s);
  assign cmd_high = (cmd == CMD_HIGH);
  assign cmd_low  = (cmd == CMD_LOW);
  assign cmd_mid  = (cmd == CMD_MID);

  // ---- state ----
  gdrv_state_e st_q, st_d;
  logic lock_q, fault_q;
  logic lock_set, lock_clr, fault_set;

  // ---- timers ----
  logic mid_expired, dead_ok, timed_out, in_wait;
  logic [GW-1:0] gap_cnt;

  gdrv_mid_timer #(.HOLD_CYC(MID_HOLD_CYC)) u_mid (
    .clk(clk), .rst_n(rst_n), .mid_now(cmd_mid), .expired(mid_expired));

  assign in_wait = (st_q == ST_WAIT_LS_OFF) || (st_q == ST_WAIT_HS_OFF);

  gdrv_gap_timer #(.DEAD_CYC(DEAD_MIN_CYC), .TMO_CYC(SENSE_TMO_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .waiting(in_wait), .restart(st_d != st_q),
    .dead_ok(dead_ok), .timed_out(timed_out), .gap_cnt(gap_cnt));

  // ---- named internal events ----
  logic hold_off, ls_allowed, trunc_evt, hs_turn_on, ls_turn_on;
  assign hold_off   = !supply_s || ot_s || fault_q;
  assign ls_allowed = cont_s || !lock_q;
  assign trunc_evt  = !cont_s && zc_s;
  assign hs_turn_on = (st_d == ST_HS_ON) && (st_q != ST_HS_ON);
  assign ls_turn_on = (st_d == ST_LS_ON) && (st_q != ST_LS_ON);

  always_comb begin
    st_d      = st_q;
    lock_set  = 1'b0;
    lock_clr  = 1'b0;
    fault_set = 1'b0;
    if (hold_off) begin
      st_d = ST_OFF;
    end else if (mid_expired) begin
      st_d = ST_SLEEP;
    end else begin
      case (st_q)
        ST_OFF, ST_SLEEP: begin
          if (cmd_high)                      st_d = ST_WAIT_LS_OFF;
          else if (cmd_low && ls_allowed)    st_d = ST_WAIT_HS_OFF;
        end
        ST_LS_ON: begin
          if (cmd_high) st_d = ST_WAIT_LS_OFF;
          else if (trunc_evt) begin
            st_d     = ST_OFF;
            lock_set = 1'b1;
          end
        end
        ST_WAIT_LS_OFF: begin
          if (!cmd_high)                 st_d = ST_OFF;
          else if (ls_off_s && dead_ok)  st_d = ST_HS_ON;
          else if (timed_out && !ls_off_s) begin
            st_d      = ST_OFF;
            fault_set = 1'b1;
          end
        end
        ST_HS_ON: begin
          if (cmd_low) begin
            st_d     = ST_WAIT_HS_OFF;
            lock_clr = 1'b1;
          end
        end
        ST_WAIT_HS_OFF: begin
          if (!(cmd_low && ls_allowed))  st_d = ST_OFF;
          else if (hs_off_s && dead_ok)  st_d = ST_LS_ON;
          else if (timed_out && !hs_off_s) begin
            st_d      = ST_OFF;
            fault_set = 1'b1;
          end
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      lock_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      fault_q <= fault_q || fault_set;
      if (cont_s || lock_clr) lock_q <= 1'b0;
      else if (lock_set)      lock_q <= 1'b1;
    end
  end

  assign hs_gate_en  = (st_q == ST_HS_ON);
  assign ls_gate_en  = (st_q == ST_LS_ON);
  assign sense_fault = fault_q;

  // ---- assertions ----
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate_en && ls_gate_en));

  assert_hs_sense_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate_en) |-> $past(ls_off_s) && !$past(ls_gate_en));

  assert_ls_sense_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate_en) |-> $past(hs_off_s) && !$past(hs_gate_en));

  assert_hs_dead_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate_en) |-> (int'($past(gap_cnt)) + 1 >= DEAD_MIN_CYC));

  assert_ls_dead_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate_en) |-> (int'($past(gap_cnt)) + 1 >= DEAD_MIN_CYC));

  assert_supply_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_s |=> (!hs_gate_en && !ls_gate_en));

  assert_trunc_ls_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_gate_en && !cont_s && zc_s) |=> !ls_gate_en);

  assert_overtemp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ot_s |=> (!hs_gate_en && !ls_gate_en));

  assert_fault_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sense_fault) |-> (sense_fault && !hs_gate_en && !ls_gate_en));

endmodule

// File: tb/tb_gdrv_sequencer.sv
module tb_gdrv_sequencer;

  localparam int MID_HOLD = 12;
  localparam int DEAD     = 3;
  localparam int TMO      = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, hi_f, lo_f, sup, cont, zc, hs_sen, ls_sen, ot;
  logic stuck_hs, stuck_ls, mon_en, done;
  logic hs_en, ls_en, flt;

  gdrv_sequencer #(.MID_HOLD_CYC(MID_HOLD), .DEAD_MIN_CYC(DEAD),
                   .SENSE_TMO_CYC(TMO), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_hi_flag(hi_f), .cmd_lo_flag(lo_f),
    .supply_ok(sup), .cont_mode(cont), .zero_cross(zc),
    .hs_off_sense(hs_sen), .ls_off_sense(ls_sen), .over_temp(ot),
    .hs_gate_en(hs_en), .ls_gate_en(ls_en), .sense_fault(flt));

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected steady gates {hs,ls} for a command code: 1 high, 2 low, 0/3 mid.
  function automatic logic [1:0] steady_gates(input int code);
    if (code == 1) return 2'b10;
    if (code == 2) return 2'b01;
    return 2'b00;
  endfunction
  function automatic int mid_drop_edge(input int hold);  return hold + 2; endfunction
  function automatic int start_edge(input int dead);     return dead + 3; endfunction
  function automatic int flag_edge();                    return 3;        endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cmd(input int code);
    hi_f = (code == 1) || (code == 3);
    lo_f = (code == 2) || (code == 3);
  endtask

  // Gate-sense model: reports a gate discharged half a cycle after disable.
  always @(negedge clk) begin
    hs_sen <= stuck_hs ? 1'b0 : !hs_en;
    ls_sen <= stuck_ls ? 1'b0 : !ls_en;
  end

  // Port monitor: overlap (R5) and both-off gap at each handover (R7).
  int off_run = 0;
  int last_on = 0;
  logic prev_hs = 1'b0, prev_ls = 1'b0;
  always @(negedge clk) begin
    if (!rst_n || !mon_en) begin
      off_run = 0; last_on = 0; prev_hs = 1'b0; prev_ls = 1'b0;
    end else begin
      chk("R5 overlap", int'(hs_en && ls_en), 0);
      if (hs_en && !prev_hs && last_on == 2) chk("R7 gap ls->hs", int'(off_run >= DEAD), 1);
      if (ls_en && !prev_ls && last_on == 1) chk("R7 gap hs->ls", int'(off_run >= DEAD), 1);
      if (hs_en) last_on = 1;
      if (ls_en) last_on = 2;
      off_run = (hs_en || ls_en) ? 0 : off_run + 1;
      prev_hs = hs_en; prev_ls = ls_en;
    end
  end

  initial begin
    done = 1'b0;
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int rs;
    rs = $urandom(32'h5EED1);
    rst_n = 1'b0; sup = 1'b0; cont = 1'b1; zc = 1'b0; ot = 1'b0;
    stuck_hs = 1'b0; stuck_ls = 1'b0; mon_en = 1'b1;
    hs_sen = 1'b1; ls_sen = 1'b1;
    set_cmd(2);
    tick(3);
    chk("R8 reset hs", int'(hs_en), 0);
    chk("R8 reset ls", int'(ls_en), 0);
    chk("R12 reset fault", int'(flt), 0);
    rst_n = 1'b1;
    tick(10);
    chk("R8 supply low ls", int'(ls_en), 0);
    // Supply becomes good with low command.
    sup = 1'b1;
    tick(start_edge(DEAD) - 1);
    chk("R8 ls not yet", int'(ls_en), 0);
    tick(1);
    chk("R8 ls on", int'(ls_en), 1);
    // High then low.
    set_cmd(1); tick(20);
    chk("R1 hs", int'(hs_en), 1);
    chk("R1 ls", int'(ls_en), 0);
    set_cmd(2); tick(20);
    chk("R2 ls", int'(ls_en), 1);
    chk("R2 hs", int'(hs_en), 0);
    // Midlevel hold exact edge.
    set_cmd(0);
    tick(mid_drop_edge(MID_HOLD) - 1);
    chk("R3 before hold", int'(ls_en), 1);
    tick(1);
    chk("R3 after hold", int'(ls_en), 0);
    // Exit sleep with low command, no hold.
    set_cmd(2);
    tick(start_edge(DEAD) - 1);
    chk("R4 ls not yet", int'(ls_en), 0);
    tick(1);
    chk("R4 ls exit", int'(ls_en), 1);
    // Short midlevel (both flags set) keeps state.
    set_cmd(3);
    for (int i = 0; i < MID_HOLD - 1; i++) begin
      tick(1);
      chk("R3 short mid", int'(ls_en), 1);
    end
    set_cmd(2); tick(6);
    chk("R3 short mid end", int'(ls_en), 1);
    // Long midlevel then exit with high.
    set_cmd(0); tick(MID_HOLD + 6);
    chk("R3 sleep", int'(ls_en || hs_en), 0);
    set_cmd(1);
    tick(start_edge(DEAD) - 1);
    chk("R4 hs not yet", int'(hs_en), 0);
    tick(1);
    chk("R4 hs exit", int'(hs_en), 1);
    // Pulse skipping.
    set_cmd(2); tick(20);
    cont = 1'b0; tick(6);
    chk("R9 skip no zc ls", int'(ls_en), 1);
    zc = 1'b1;
    tick(flag_edge() - 1);
    chk("R10 ls before trunc", int'(ls_en), 1);
    tick(1);
    chk("R10 trunc", int'(ls_en), 0);
    zc = 1'b0; tick(12);
    chk("R10 locked", int'(ls_en), 0);
    set_cmd(1); tick(20);
    chk("R10 hs pulse", int'(hs_en), 1);
    set_cmd(2); tick(20);
    chk("R10 ls after pulse", int'(ls_en), 1);
    cont = 1'b1; tick(6);
    zc = 1'b1; tick(12);
    chk("R9 zc ignored", int'(ls_en), 1);
    zc = 1'b0;
    // Over-temperature.
    set_cmd(1); tick(20);
    ot = 1'b1;
    tick(flag_edge() - 1);
    chk("R11 hs before", int'(hs_en), 1);
    tick(1);
    chk("R11 hs off", int'(hs_en), 0);
    tick(10);
    chk("R11 held", int'(hs_en || ls_en), 0);
    ot = 1'b0; tick(20);
    chk("R11 resume", int'(hs_en), 1);
    // Constrained random command sequence.
    for (int i = 0; i < 80; i++) begin
      int code;
      code = int'($urandom_range(3, 0));
      cont = 1'(($urandom_range(1, 0)));
      set_cmd(code);
      if ($urandom_range(3, 0) == 0) begin
        tick(int'($urandom_range(MID_HOLD - 1, 1)));
      end else begin
        tick(MID_HOLD + DEAD + 10);
        chk(code == 1 ? "R1 random" : (code == 2 ? "R2 random" : "R3 random"),
            int'({hs_en, ls_en}), int'(steady_gates(code)));
      end
    end
    // Stuck low-side sense: timeout fault.
    cont = 1'b1; set_cmd(2); tick(20);
    stuck_ls = 1'b1;
    set_cmd(1);
    tick(TMO + 12);
    chk("R12 fault", int'(flt), 1);
    chk("R6 hs blocked", int'(hs_en), 0);
    chk("R12 ls off", int'(ls_en), 0);
    stuck_ls = 1'b0; tick(20);
    chk("R12 sticky", int'(flt), 1);
    chk("R12 still off", int'(hs_en), 0);
    rst_n = 1'b0; tick(2);
    rst_n = 1'b1; tick(20);
    chk("R12 cleared", int'(flt), 0);
    chk("R1 after reset", int'(hs_en), 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule